// File: doc/BRIEF.md
# Exception and Status Control Coprocessor

This block holds the system-control state of a small 32-bit RISC CPU: a status word, a cause word, a saved return address and a read-only identity word. These sit with a few general control entries in a 16-entry register file that the core reads and writes by index through move-from and move-to operations. Each cycle it merges the synchronous exception requests from the pipeline with an interrupt that it derives itself. It then picks one cause, lowest code first, and in that same cycle drives a redirect address with a one-cycle valid strobe.

When a cause is taken, the block records the code and the delay-slot flag in the cause word. It saves the address to return to and shifts a three-level, two-bit-per-level stack of enable/mode bits held in the bottom of the status word. A return-from-exception operation shifts the stack back. The block also gates the core's store-enable while a status bit isolates the cache. Decode, the pipeline, caches, address translation and debug matching lie outside it.

Top module: `sysctl_cop`

## Requirements
- R1: After reset, entry 12 (status) reads 0x10900000, entry 15 (identity) reads 0x00000002, every other entry reads 0, and vec_valid is 0.
- R2: rd_data shows entry rd_idx combinationally. A move-to (wr_en) writes wr_data into entry wr_idx at the clock edge.
- R3: Entry 15 is read-only: a move-to at index 15 leaves it at 0x00000002.
- R4: Cause bit 10 takes the level of irq_line at every clock edge. A move-to into that bit does not persist.
- R5: An interrupt (code 0) is requested when status bit 0, status bit 10 and cause bit 10 are all 1. exc_req[0] also requests code 0.
- R6: At most one cause is taken per cycle, and the lowest requested code wins. A taken cause cancels a move-to and a return in the same cycle.
- R7: On entry, cause bits [6:0] are cleared, the code is placed in bits [6:2], and bit 31 is set to in_delay. All other cause bits keep their values.
- R8: On entry, entry 14 receives instr_pc, or instr_pc minus 4 (modulo 2^32) when in_delay is 1.
- R9: On entry, status bits [5:0] become the old bits [3:0] followed by two zero bits. Status bits [31:6] are unchanged.
- R10: On exc_ret, status bits [3:0] take the old bits [5:2], and bits [31:4] are unchanged. If a move-to at index 12 arrives in the same cycle, that move-to is dropped.
- R11: vec_valid is 1 in the cycle a cause is taken. vec_addr is then 0xBFC00180 if status bit 22 is 1, and 0x80000080 otherwise.
- R12: store_en equals store_req while status bit 16 is 0, and is 0 while that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 4 | Move-from index |
| rd_data | output | 32 | Move-from data |
| wr_en | input | 1 | Move-to strobe |
| wr_idx | input | 4 | Move-to index |
| wr_data | input | 32 | Move-to data |
| exc_ret | input | 1 | Return-from-exception strobe |
| exc_req | input | 16 | One request bit per exception code |
| in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| instr_pc | input | 32 | Address of the faulting instruction |
| irq_line | input | 1 | External interrupt level |
| vec_valid | output | 1 | A cause is taken this cycle |
| vec_addr | output | 32 | Redirect address |
| store_req | input | 1 | Core wants to store |
| store_en | output | 1 | Store enable to memory |

## Verification
A vector table drives exception entry from several starting stack patterns: all-ones, alternating bits, a single set bit and a pattern whose top level falls off. These patterns separate a correct two-bit shift from a shift in the wrong direction or a stack without a mask. The table mixes delay-slot and non-delay-slot cases, including a program counter of zero that wraps, and request vectors with several bits set, so that lowest-first priority is told apart from highest-first. Directed cases cover the delayed interrupt pending bit, masked and unmasked interrupts, the interrupt winning over a synchronous request, a return pop, the read-only identity entry, and a taken cause cancelling a move-to and a return in the same cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN       = 32;
  localparam int CODE_W     = 5;
  localparam int IDX_STATUS = 12;
  localparam int IDX_CAUSE  = 13;
  localparam int IDX_RETPC  = 14;
  localparam int IDX_IDENT  = 15;
  localparam int BIT_IEC    = 0;
  localparam int BIT_IM     = 10;
  localparam int BIT_ISOL   = 16;
  localparam int BIT_BOOTV  = 22;
  localparam int BIT_BD     = 31;

  typedef logic [XLEN-1:0] word_t;

  // stack push: each 2-bit level moves up one place, new level is zero
  function automatic word_t push_mode(word_t s);
    return {s[XLEN-1:6], s[3:0], 2'b00};
  endfunction

  // stack pop: top level stays, the two lower levels move down
  function automatic word_t pop_mode(word_t s);
    return {s[XLEN-1:4], s[5:2]};
  endfunction

  function automatic word_t cause_on_entry(word_t c, logic [CODE_W-1:0] code, logic bd);
    return {bd, c[XLEN-2:7], code, 2'b00};
  endfunction

  function automatic word_t return_addr(word_t pc, logic bd);
    return bd ? (pc - word_t'(4)) : pc;
  endfunction

  function automatic word_t vector_of(word_t s, word_t boot_v, word_t norm_v);
    return s[BIT_BOOTV] ? boot_v : norm_v;
  endfunction
endpackage

// File: rtl/sysctl_prio.sv
module sysctl_prio #(
  parameter int N = 16,
  parameter int W = 5
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] code
);
  always_comb begin
    any  = |req;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = W'(i);
    end
  end
endmodule

// File: rtl/sysctl_irq_eval.sv
module sysctl_irq_eval (
  input  logic status_iec,
  input  logic status_im,
  input  logic cause_pend,
  output logic int_req
);
  assign int_req = status_iec & status_im & cause_pend;
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int    IDX_W      = 4,
  parameter word_t RST_STATUS = 32'h1090_0000,
  parameter word_t IDENT      = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output word_t             rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  word_t             wr_data,
  input  logic              pop,
  input  logic              take,
  input  logic [CODE_W-1:0] take_code,
  input  logic              in_delay,
  input  word_t             instr_pc,
  input  logic              irq_line,
  output word_t             status_q,
  output word_t             cause_q,
  output word_t             retpc_q,
  output word_t             ident_q
);
  localparam int DEPTH = 1 << IDX_W;

  word_t regs [DEPTH];
  word_t nxt  [DEPTH];
  logic  wr_ok;

  // a move-to survives only when no cause is taken, the entry is writable,
  // and a pop does not claim the status entry
  assign wr_ok = wr_en && !take && (int'(wr_idx) != IDX_IDENT) &&
                 !(pop && int'(wr_idx) == IDX_STATUS);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) nxt[i] = regs[i];
    if (take) begin
      nxt[IDX_STATUS] = push_mode(regs[IDX_STATUS]);
      nxt[IDX_CAUSE]  = cause_on_entry(regs[IDX_CAUSE], take_code, in_delay);
      nxt[IDX_RETPC]  = return_addr(instr_pc, in_delay);
    end else begin
      if (wr_ok) nxt[wr_idx] = wr_data;
      if (pop)   nxt[IDX_STATUS] = pop_mode(regs[IDX_STATUS]);
    end
    nxt[IDX_CAUSE][BIT_IM] = irq_line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == IDX_STATUS)     regs[i] <= RST_STATUS;
        else if (i == IDX_IDENT) regs[i] <= IDENT;
        else                     regs[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= nxt[i];
    end
  end

  assign rd_data  = regs[rd_idx];
  assign status_q = regs[IDX_STATUS];
  assign cause_q  = regs[IDX_CAUSE];
  assign retpc_q  = regs[IDX_RETPC];
  assign ident_q  = regs[IDX_IDENT];
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int    IDX_W      = 4,
  parameter int    REQ_N      = 16,
  parameter logic [31:0] RST_STATUS = 32'h1090_0000,
  parameter logic [31:0] IDENT      = 32'h0000_0002,
  parameter logic [31:0] VEC_BOOT   = 32'hBFC0_0180,
  parameter logic [31:0] VEC_NORM   = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              exc_ret,
  input  logic [REQ_N-1:0]  exc_req,
  input  logic              in_delay,
  input  logic [31:0]       instr_pc,
  input  logic              irq_line,
  output logic              vec_valid,
  output logic [31:0]       vec_addr,
  input  logic              store_req,
  output logic              store_en
);
  // named internal events, observed by the bound checker
  logic              int_req;
  logic              take;
  logic [CODE_W-1:0] take_code;
  logic [REQ_N-1:0]  all_req;
  word_t             status_q, cause_q, retpc_q, ident_q;

  sysctl_irq_eval u_irq (
    .status_iec (status_q[BIT_IEC]),
    .status_im  (status_q[BIT_IM]),
    .cause_pend (cause_q[BIT_IM]),
    .int_req    (int_req)
  );

  assign all_req = exc_req | REQ_N'(int_req);

  sysctl_prio #(.N(REQ_N), .W(CODE_W)) u_prio (
    .req  (all_req),
    .any  (take),
    .code (take_code)
  );

  sysctl_regfile #(
    .IDX_W(IDX_W), .RST_STATUS(RST_STATUS), .IDENT(IDENT)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .pop       (exc_ret),
    .take      (take),
    .take_code (take_code),
    .in_delay  (in_delay),
    .instr_pc  (instr_pc),
    .irq_line  (irq_line),
    .status_q  (status_q),
    .cause_q   (cause_q),
    .retpc_q   (retpc_q),
    .ident_q   (ident_q)
  );

  assign vec_valid = take;
  assign vec_addr  = vector_of(status_q, VEC_BOOT, VEC_NORM);
  assign store_en  = store_req & ~status_q[BIT_ISOL];
endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk #(
  parameter int REQ_N = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_ret,
  input logic             in_delay,
  input logic [31:0]      instr_pc,
  input logic             irq_line,
  input logic             vec_valid,
  input logic [31:0]      vec_addr,
  input logic             store_en,
  input logic             int_req,
  input logic [4:0]       take_code,
  input logic [REQ_N-1:0] all_req,
  input logic [31:0]      status_q,
  input logic [31:0]      cause_q,
  input logic [31:0]      retpc_q,
  input logic [31:0]      ident_q
);
  a_r3_ident_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ident_q));

  a_r4_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cause_q[10] == $past(irq_line));

  a_r5_int_taken: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> vec_valid && take_code == 5'd0);

  a_r6_code_requested: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> |(all_req & (REQ_N'(1) << take_code)));

  a_r7_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> cause_q[6:2] == $past(take_code) && cause_q[31] == $past(in_delay)
                  && cause_q[1:0] == 2'b00);

  a_r8_retpc: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !in_delay |=> retpc_q == $past(instr_pc));

  a_r9_push: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> status_q[5:0] == {$past(status_q[3:0]), 2'b00}
                  && status_q[31:6] == $past(status_q[31:6]));

  a_r10_pop: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret && !vec_valid |=> status_q[3:0] == $past(status_q[5:2])
                             && status_q[5:4] == $past(status_q[5:4]));

  a_r11_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr == 32'hBFC0_0180) == status_q[22]);

  a_r12_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[16] |-> !store_en);
endmodule

bind sysctl_cop sysctl_cop_chk #(.REQ_N(REQ_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_ret   (exc_ret),
  .in_delay  (in_delay),
  .instr_pc  (instr_pc),
  .irq_line  (irq_line),
  .vec_valid (vec_valid),
  .vec_addr  (vec_addr),
  .store_en  (store_en),
  .int_req   (int_req),
  .take_code (take_code),
  .all_req   (all_req),
  .status_q  (status_q),
  .cause_q   (cause_q),
  .retpc_q   (retpc_q),
  .ident_q   (ident_q)
);

// File: tb/sysctl_cop_bench.sv
module sysctl_cop_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        exc_ret = 1'b0;
  logic [15:0] exc_req = '0;
  logic        in_delay = 1'b0;
  logic [31:0] instr_pc = '0;
  logic        irq_line = 1'b0;
  logic        vec_valid;
  logic [31:0] vec_addr;
  logic        store_req = 1'b0;
  logic        store_en;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sysctl_cop u_sysctl_cop (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .exc_ret(exc_ret),
    .exc_req(exc_req), .in_delay(in_delay), .instr_pc(instr_pc),
    .irq_line(irq_line), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .store_req(store_req), .store_en(store_en)
  );

  typedef struct packed {
    logic [31:0] st;
    logic        bd;
    logic [31:0] pc;
    logic [15:0] req;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{st:32'h1090_0005, bd:1'b0, pc:32'h8000_1000, req:16'h0100},
    '{st:32'h1090_003F, bd:1'b1, pc:32'h8000_2004, req:16'h1010},
    '{st:32'h0040_002A, bd:1'b0, pc:32'hBFC0_0100, req:16'h0400},
    '{st:32'h0000_0001, bd:1'b1, pc:32'h0000_0000, req:16'h0220},
    '{st:32'h0001_0010, bd:1'b0, pc:32'h1234_5678, req:16'h1000}
  };
  localparam logic [31:0] CAUSE_SEED = 32'h5A5A_5BFF;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic move_to(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [31:0] d);
    rd_idx = idx;
    #1;
    d = rd_data;
  endtask

  function automatic int lowest(input logic [15:0] r);
    for (int i = 15; i >= 0; i--) if (r[i]) lowest = i;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected 0 remaining cycles", 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    peek(4'd12, v); check(v, 32'h1090_0000, "R1 status");
    peek(4'd15, v); check(v, 32'h0000_0002, "R1 ident");
    peek(4'd13, v); check(v, 32'h0, "R1 cause");
    peek(4'd14, v); check(v, 32'h0, "R1 retpc");
    peek(4'd3,  v); check(v, 32'h0, "R1 entry3");
    check({31'd0, vec_valid}, 32'd0, "R1 vec_valid");

    // R2 generic entry
    move_to(4'd3, 32'hCAFE_F00D);
    peek(4'd3, v); check(v, 32'hCAFE_F00D, "R2 readback");
    // R3 identity read-only
    move_to(4'd15, 32'h0000_DEAD);
    peek(4'd15, v); check(v, 32'h0000_0002, "R3 ident write ignored");
    // R4 cause bit 10 not writable
    move_to(4'd13, 32'h0000_0400);
    peek(4'd13, v); check(v, 32'h0, "R4 pend write dropped");

    // table of exception entries: R6 R7 R8 R9 R11
    foreach (TBL[k]) begin
      logic [31:0] e_st, e_cause, e_pc, e_vec;
      int code;
      code    = lowest(TBL[k].req);
      e_st    = (TBL[k].st & ~32'h3F) | ((TBL[k].st << 2) & 32'h3F);
      e_cause = (CAUSE_SEED & 32'h7FFF_FF80) | (32'(code) << 2) | (32'(TBL[k].bd) << 31);
      e_pc    = TBL[k].bd ? TBL[k].pc + 32'hFFFF_FFFC : TBL[k].pc;
      e_vec   = ((TBL[k].st >> 22) & 1) != 0 ? 32'hBFC0_0180 : 32'h8000_0080;
      move_to(4'd12, TBL[k].st);
      move_to(4'd13, CAUSE_SEED);
      exc_req = TBL[k].req; in_delay = TBL[k].bd; instr_pc = TBL[k].pc;
      #1;
      check({31'd0, vec_valid}, 32'd1, "R11 valid strobe");
      check(vec_addr, e_vec, "R11 vector");
      @(negedge clk);
      exc_req = '0; in_delay = 1'b0;
      peek(4'd12, v); check(v, e_st, "R9 push");
      peek(4'd13, v); check(v, e_cause, "R7 R6 cause code");
      peek(4'd14, v); check(v, e_pc, "R8 return address");
    end

    // R10 pop
    move_to(4'd12, 32'h0000_003B);
    @(negedge clk);
    exc_ret = 1'b1;
    @(negedge clk);
    exc_ret = 1'b0;
    peek(4'd12, v); check(v, 32'h0000_003E, "R10 pop");
    // R10 pop beats a status move-to
    @(negedge clk);
    exc_ret = 1'b1; wr_en = 1'b1; wr_idx = 4'd12; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    exc_ret = 1'b0; wr_en = 1'b0;
    peek(4'd12, v); check(v, 32'h0000_003F, "R10 pop over move-to");

    // R6 taken cause cancels move-to and return
    move_to(4'd12, 32'h0000_0015);
    exc_req = 16'h0200; exc_ret = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h1111_1111;
    @(negedge clk);
    exc_req = '0; exc_ret = 1'b0; wr_en = 1'b0;
    peek(4'd3, v);  check(v, 32'hCAFE_F00D, "R6 move-to cancelled");
    peek(4'd12, v); check(v, 32'h0000_0014, "R6 push not pop");

    // R4 R5 interrupt, one cycle after irq_line rises; beats code 8
    move_to(4'd12, 32'h0000_0401);
    irq_line = 1'b1;
    #1;
    check({31'd0, vec_valid}, 32'd0, "R4 pend not yet seen");
    @(negedge clk);
    exc_req = 16'h0100;
    #1;
    check({31'd0, vec_valid}, 32'd1, "R5 interrupt taken");
    check(vec_addr, 32'h8000_0080, "R11 normal vector");
    @(negedge clk);
    exc_req = '0;
    peek(4'd12, v); check(v, 32'h0000_0404, "R5 push clears enable");
    peek(4'd13, v); check(v & 32'h0000_047C, 32'h0000_0400, "R5 R6 code 0 with pend");
    check({31'd0, vec_valid}, 32'd0, "R5 no repeat after push");
    // masked interrupt
    move_to(4'd12, 32'h0000_0001);
    @(negedge clk);
    #1;
    check({31'd0, vec_valid}, 32'd0, "R5 masked");
    irq_line = 1'b0;
    @(negedge clk);
    peek(4'd13, v); check(v & 32'h400, 32'h0, "R4 pend follows low");

    // R12 store gating
    move_to(4'd12, 32'h0001_0000);
    store_req = 1'b1;
    #1;
    check({31'd0, store_en}, 32'd0, "R12 isolated");
    move_to(4'd12, 32'h0000_0000);
    #1;
    check({31'd0, store_en}, 32'd1, "R12 passed");
    store_req = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule